// File: doc/BRIEF.md
# Floating-Point Subnormal Trap Decision Unit

This block is the post-processing stage behind a single- and double-precision floating-point datapath. The datapath reports several facts about an operation:

- the operation kind;
- a class code for each source operand and for the rounded result;
- an estimate of the biased result exponent;
- the result sign;
- the rounding mode;
- its raw exception flags.

The unit also receives the trap enable mask and two mode bits.

From these inputs it decides whether the operation completes in hardware or must be handed to software as an unfinished operation. When it completes, the unit also decides whether the result is replaced by zero (gross underflow or flush-to-zero) or by the default quiet NaN. It also settles the trap type and the final current-exception flags.

Two handling regimes exist. Standard handling is in force whenever the non-standard bit is clear or the interval-arithmetic bit is set. In that regime subnormal cases mostly trap as unfinished. Flush handling is in force only when the non-standard bit is set and the interval bit is clear. There, subnormal operands are treated as zero and replacement flags are raised instead. A strobe on `in_valid` captures a decision, and the decision appears on the outputs one clock later.

Top module: `fp_subnorm_trap_unit`

## Requirements
- R1: One cycle after `in_valid` is high, `out_valid` is high and the outputs hold the decision for that input. One cycle after `in_valid` is low, `out_valid` is low. Reset (`rst` high) clears `out_valid`.
- R2: Flush handling applies only when `nonstd`=1 and `interval`=0. Every other combination of the two bits selects standard handling.
- R3: In standard handling, an add or subtract with a subnormal operand and no NaN or infinity operand gives trap type 2 (unfinished). The same holds for a conversion, and for a single-to-double multiply that also has no zero operand.
- R4: In standard handling, a multiply or divide with a subnormal operand and no NaN, infinity or zero operand gives unfinished in either of two cases:
  - EGUF < Er < EMAX;
  - Er ≤ EGUF with a positive result and rounding toward +inf (code 2), or with a negative result and rounding toward −inf (code 3).

  Otherwise it forces a zero result. A divide with Er ≥ EMAX gives a gross-overflow result instead. For single precision EMAX is 255 and EGUF is −24; for double precision they are 2047 and −53.
- R5: In standard handling, the square root of a negative subnormal raises invalid and forces the default QNaN. It traps as an IEEE exception only if invalid is enabled. A positive subnormal operand gives unfinished. Force-zero and force-QNaN are never both high.
- R6: A result counts as subnormal if its class is ±subnormal, or if its class is ±zero while both raw underflow and raw inexact are set.
- R7: In flush handling, with normal operands and a subnormal result:
  - add, subtract and double-to-single force zero;
  - multiply and divide force zero when Er < EMAX, and give gross overflow otherwise.
- R8: In flush handling, a divide with a subnormal operand and no NaN or infinity operand replaces the raw flags:
  - both operands subnormal gives invalid only;
  - only the divisor subnormal gives divide-by-zero only;
  - only the dividend subnormal gives inexact only;
  - a zero operand gives invalid only.
- R9: When no trap has been decided by the subnormal rules, the remaining conditions are taken in this order: raw overflow (gross overflow), then enabled divide-by-zero (IEEE trap), then enabled invalid (IEEE trap), then raw underflow on an operation with no subnormal operand or result (underflow result). After that, enabled inexact traps unless a zero or overflow result was chosen.
- R10: A forced-zero or underflow result behaves as follows:
  - with the underflow and inexact enables both clear, there is no trap and the flags are underflow|inexact;
  - otherwise there is an IEEE trap, and the flags are underflow alone if underflow is enabled, else inexact alone.
- R11: A gross-overflow result behaves as follows:
  - with the overflow and inexact enables both clear, there is no trap and the flags are overflow|inexact;
  - otherwise there is an IEEE trap, and the flags are overflow alone if overflow is enabled, else inexact alone.
- R12: The encodings are as follows.
  - Trap type: 0 none, 1 IEEE exception, 2 unfinished; 3 never appears.
  - Flag and mask bits, from bit 4 down to bit 0: invalid, overflow, underflow, divide-by-zero, inexact.
  - Operation code: 0 add, 1 subtract, 2 multiply, 3 divide, 4 single-to-double multiply, 5 square root, 6 conversion, 7 double-to-single.
  - Class code: 0 none, 1 normal, 2 +zero, 3 −zero, 4 +subnormal, 5 −subnormal, 6 infinity, 7 quiet NaN, 8 signalling NaN.
  - Rounding code: 0 nearest, 1 toward zero, 2 toward +inf, 3 toward −inf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Captures the current inputs |
| op | input | 3 | Operation code (R12) |
| dbl | input | 1 | Destination precision, 1 = double |
| cls_a | input | 4 | Class of first operand (0 for unary operations) |
| cls_b | input | 4 | Class of second or only operand |
| cls_r | input | 4 | Class of the rounded result |
| exp_est | input | ER_W | Signed biased exponent estimate Er |
| res_neg | input | 1 | Result sign, 1 = negative |
| rnd_mode | input | 2 | Rounding mode code |
| trap_en | input | 5 | Trap enable mask |
| nonstd | input | 1 | Non-standard (flush) request |
| interval | input | 1 | Interval-arithmetic mode |
| raw_flags | input | 5 | Exception flags raised by the datapath |
| out_valid | output | 1 | Decision valid |
| trap_kind | output | 2 | Trap type |
| cexc | output | 5 | Final current-exception flags |
| force_zero | output | 1 | Replace the result by zero of its sign |
| force_qnan | output | 1 | Replace the result by the default quiet NaN |

## Verification
The bench aims at the exponent boundaries of the multiply and divide window.

- An Er just below EGUF must flip between forced zero and unfinished according to the sign and the directed rounding mode. A design with the comparison reversed would hand gross underflows to software, or silently zero a result it cannot produce.
- A result of class zero must count as subnormal only when underflow and inexact are both raw. A design that omits this condition misses the forced zero, or zeroes exact results.
- In flush division, the invalid, divide-by-zero and inexact replacement codes must follow which operand is subnormal. Swapped operand roles would report divide-by-zero for a tiny dividend.
- The post-check order must let raw overflow outrank an enabled invalid flag, and the enable-dependent flag selection for the overflow and underflow results must be honoured. A design that gets either wrong reports the wrong trap type or a doubled flag set.

// File: rtl/fpchk_pkg.sv
package fpchk_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_MUL   = 3'd2,
        OP_DIV   = 3'd3,
        OP_SMULD = 3'd4,
        OP_SQRT  = 3'd5,
        OP_CVT   = 3'd6,
        OP_DTOS  = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        CL_NONE  = 4'd0,
        CL_NORM  = 4'd1,
        CL_PZERO = 4'd2,
        CL_NZERO = 4'd3,
        CL_PSUB  = 4'd4,
        CL_NSUB  = 4'd5,
        CL_INF   = 4'd6,
        CL_QNAN  = 4'd7,
        CL_SNAN  = 4'd8
    } cls_e;

    typedef enum logic [1:0] {
        TT_NONE  = 2'd0,
        TT_IEEE  = 2'd1,
        TT_UNFIN = 2'd2
    } trap_e;

    localparam int FLAG_W = 5;
    localparam int FL_NV  = 4;
    localparam int FL_OF  = 3;
    localparam int FL_UF  = 2;
    localparam int FL_DZ  = 1;
    localparam int FL_NX  = 0;

    localparam logic [1:0] RM_POS = 2'd2;
    localparam logic [1:0] RM_NEG = 2'd3;

    // Decoded operand class
    typedef struct packed {
        logic none;
        logic norm;
        logic zero;
        logic sub;
        logic nsub;
        logic inf;
        logic nan;
    } opnd_t;

    // Verdict of the subnormal rules
    typedef struct packed {
        logic              unf;
        logic              guzr;
        logic              gor;
        logic              ovr;
        logic [FLAG_W-1:0] flags;
        logic              qnan;
        logic              nil;
    } verdict_t;

    // Final decision
    typedef struct packed {
        logic [1:0]        trap;
        logic [FLAG_W-1:0] cexc;
        logic              fz;
        logic              fq;
    } result_t;

    function automatic opnd_t decode_cls(input logic [3:0] code);
        opnd_t d;
        d      = '0;
        d.none = (code == CL_NONE);
        d.norm = (code == CL_NORM);
        d.zero = (code == CL_PZERO) || (code == CL_NZERO);
        d.sub  = (code == CL_PSUB)  || (code == CL_NSUB);
        d.nsub = (code == CL_NSUB);
        d.inf  = (code == CL_INF);
        d.nan  = (code == CL_QNAN)  || (code == CL_SNAN);
        return d;
    endfunction

    function automatic logic [FLAG_W-1:0] one_flag(input int pos);
        logic [FLAG_W-1:0] f;
        f      = '0;
        f[pos] = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/fpchk_opclass.sv
module fpchk_opclass
    import fpchk_pkg::*;
(
    input  logic [3:0] cls_a,
    input  logic [3:0] cls_b,
    input  logic [3:0] cls_r,
    input  logic       raw_uf,
    input  logic       raw_nx,
    output opnd_t      opa,
    output opnd_t      opb,
    output logic       rsub,
    output logic       anysub
);
    opnd_t res;

    always_comb begin
        opa    = decode_cls(cls_a);
        opb    = decode_cls(cls_b);
        res    = decode_cls(cls_r);
        // a zero that underflowed inexactly stands for a lost subnormal
        rsub   = res.sub || (res.zero && raw_uf && raw_nx);
        anysub = opa.sub || opb.sub || rsub;
    end
endmodule

// File: rtl/fpchk_decide.sv
module fpchk_decide
    import fpchk_pkg::*;
#(
    parameter int ER_W    = 13,
    parameter int SP_EMAX = 255,
    parameter int SP_EGUF = -24,
    parameter int DP_EMAX = 2047,
    parameter int DP_EGUF = -53
) (
    input  op_e                     op,
    input  logic                    dbl,
    input  opnd_t                   opa,
    input  opnd_t                   opb,
    input  logic                    rsub,
    input  logic signed [ER_W-1:0]  er,
    input  logic                    res_neg,
    input  logic [1:0]              rnd,
    input  logic                    std_mode,
    output verdict_t                v
);
    int   emax, eguf, er_i;
    logic dir_ok, low, win, nan_inf_any, zero_any, opsub, both_norm;

    always_comb begin
        v           = '0;
        emax        = dbl ? DP_EMAX : SP_EMAX;
        eguf        = dbl ? DP_EGUF : SP_EGUF;
        er_i        = int'(er);
        dir_ok      = (!res_neg && rnd == RM_POS) || (res_neg && rnd == RM_NEG);
        low         = (er_i <= eguf);
        win         = ((er_i < emax) && (er_i > eguf)) || (low && dir_ok);
        nan_inf_any = opa.nan || opa.inf || opb.nan || opb.inf;
        zero_any    = opa.zero || opb.zero;
        opsub       = opa.sub || opb.sub;
        both_norm   = opb.norm && (opa.norm || opa.none);

        if (std_mode) begin
            if (opsub) begin
                case (op)
                    OP_ADD, OP_SUB, OP_CVT:
                        v.unf = !nan_inf_any;
                    OP_SMULD:
                        v.unf = !nan_inf_any && !zero_any;
                    OP_MUL: if (!nan_inf_any && !zero_any) begin
                        v.unf  = win;
                        v.guzr = !win;
                    end
                    OP_DIV: if (!nan_inf_any && !zero_any) begin
                        if (er_i < emax) begin
                            v.unf  = win;
                            v.guzr = !win;
                        end else begin
                            v.gor  = 1'b1;
                        end
                    end
                    OP_SQRT: if (!opb.nan && !opb.inf) begin
                        if (opb.nsub) begin
                            v.ovr   = 1'b1;
                            v.flags = one_flag(FL_NV);
                            v.qnan  = 1'b1;
                        end else begin
                            v.unf   = 1'b1;
                        end
                    end
                    OP_DTOS: if (!opb.nan && !opb.inf) begin
                        v.unf  = dir_ok;
                        v.guzr = !dir_ok;
                    end
                    default: ;
                endcase
            end else if (rsub && both_norm) begin
                case (op)
                    OP_ADD, OP_SUB:
                        v.unf = 1'b1;
                    OP_MUL, OP_DIV: begin
                        if (er_i < emax) begin
                            v.unf  = win;
                            v.guzr = !win;
                        end else begin
                            v.gor  = 1'b1;
                        end
                    end
                    OP_DTOS: begin
                        v.unf  = ((er_i < 1) && (er_i > eguf)) || (low && dir_ok);
                        v.guzr = !v.unf;
                    end
                    default: ;
                endcase
            end
        end else begin
            if (opsub) begin
                case (op)
                    OP_ADD, OP_SUB, OP_CVT, OP_DTOS: if (!nan_inf_any) begin
                        v.ovr   = 1'b1;
                        v.flags = one_flag(FL_NX);
                    end
                    OP_MUL, OP_SMULD: if (!opa.nan && !opb.nan && !zero_any) begin
                        v.ovr = 1'b1;
                        if (!opa.inf && !opb.inf) begin
                            v.flags = one_flag(FL_NX);
                        end else begin
                            v.flags = one_flag(FL_NV);
                            v.qnan  = 1'b1;
                        end
                    end
                    OP_DIV: if (!opa.nan && !opb.nan) begin
                        if (!opa.inf && !opb.inf && !zero_any) begin
                            v.ovr = 1'b1;
                            if (opa.sub && opb.sub)  v.flags = one_flag(FL_NV);
                            else if (opb.sub)        v.flags = one_flag(FL_DZ);
                            else                     v.flags = one_flag(FL_NX);
                        end else if (!opa.inf && !opb.inf) begin
                            v.ovr   = 1'b1;
                            v.flags = one_flag(FL_NV);
                        end
                    end
                    OP_SQRT: if (!opb.nan && !opb.inf) begin
                        v.ovr   = 1'b1;
                        v.flags = one_flag(FL_NX);
                        v.nil   = opb.nsub;
                    end
                    default: ;
                endcase
            end else if (rsub && both_norm) begin
                case (op)
                    OP_ADD, OP_SUB, OP_DTOS:
                        v.guzr = 1'b1;
                    OP_MUL, OP_DIV: begin
                        v.guzr = (er_i < emax);
                        v.gor  = !(er_i < emax);
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fpchk_resolve.sv
module fpchk_resolve
    import fpchk_pkg::*;
(
    input  verdict_t          v,
    input  logic [FLAG_W-1:0] raw,
    input  logic [FLAG_W-1:0] tem,
    input  logic              anysub,
    output result_t           r
);
    logic [FLAG_W-1:0] fef, eft;
    logic              gor, ur;
    trap_e             tt;

    always_comb begin
        fef = v.ovr ? v.flags : raw;
        eft = fef & tem;
        tt  = v.unf ? TT_UNFIN : TT_NONE;
        gor = v.gor;
        ur  = 1'b0;

        if (tt == TT_NONE) begin
            if (fef[FL_OF])                     gor = 1'b1;
            else if (eft[FL_DZ])                tt  = TT_IEEE;
            else if (eft[FL_NV])                tt  = TT_IEEE;
            else if (fef[FL_UF] && !anysub)     ur  = 1'b1;
        end
        if (eft[FL_NX] && !v.guzr && !gor && tt == TT_NONE)
            tt = TT_IEEE;

        r.cexc = fef;
        r.fz   = v.guzr || v.nil;
        r.fq   = v.qnan;

        if (v.guzr || ur) begin
            if (!tem[FL_UF] && !tem[FL_NX]) begin
                tt     = TT_NONE;
                r.cexc = one_flag(FL_UF) | one_flag(FL_NX);
            end else begin
                tt     = TT_IEEE;
                r.cexc = tem[FL_UF] ? one_flag(FL_UF) : one_flag(FL_NX);
            end
        end else if (gor) begin
            if (!tem[FL_OF] && !tem[FL_NX]) begin
                tt     = TT_NONE;
                r.cexc = one_flag(FL_OF) | one_flag(FL_NX);
            end else begin
                tt     = TT_IEEE;
                r.cexc = tem[FL_OF] ? one_flag(FL_OF) : one_flag(FL_NX);
            end
        end
        r.trap = tt;
    end
endmodule

// File: rtl/fp_subnorm_trap_unit.sv
module fp_subnorm_trap_unit
    import fpchk_pkg::*;
#(
    parameter int ER_W    = 13,
    parameter int SP_EMAX = 255,
    parameter int SP_EGUF = -24,
    parameter int DP_EMAX = 2047,
    parameter int DP_EGUF = -53
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [2:0]             op,
    input  logic                   dbl,
    input  logic [3:0]             cls_a,
    input  logic [3:0]             cls_b,
    input  logic [3:0]             cls_r,
    input  logic signed [ER_W-1:0] exp_est,
    input  logic                   res_neg,
    input  logic [1:0]             rnd_mode,
    input  logic [4:0]             trap_en,
    input  logic                   nonstd,
    input  logic                   interval,
    input  logic [4:0]             raw_flags,
    output logic                   out_valid,
    output logic [1:0]             trap_kind,
    output logic [4:0]             cexc,
    output logic                   force_zero,
    output logic                   force_qnan
);
    opnd_t    opa, opb;
    logic     rsub, anysub, std_mode;
    verdict_t verdict;
    result_t  res_d, res_q;

    assign std_mode = !nonstd || interval;

    fpchk_opclass u_cls (
        .cls_a  (cls_a),
        .cls_b  (cls_b),
        .cls_r  (cls_r),
        .raw_uf (raw_flags[FL_UF]),
        .raw_nx (raw_flags[FL_NX]),
        .opa    (opa),
        .opb    (opb),
        .rsub   (rsub),
        .anysub (anysub)
    );

    fpchk_decide #(
        .ER_W(ER_W), .SP_EMAX(SP_EMAX), .SP_EGUF(SP_EGUF),
        .DP_EMAX(DP_EMAX), .DP_EGUF(DP_EGUF)
    ) u_dec (
        .op       (op_e'(op)),
        .dbl      (dbl),
        .opa      (opa),
        .opb      (opb),
        .rsub     (rsub),
        .er       (exp_est),
        .res_neg  (res_neg),
        .rnd      (rnd_mode),
        .std_mode (std_mode),
        .v        (verdict)
    );

    fpchk_resolve u_res (
        .v      (verdict),
        .raw    (raw_flags),
        .tem    (trap_en),
        .anysub (anysub),
        .r      (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) res_q <= res_d;
        end
    end

    assign trap_kind  = res_q.trap;
    assign cexc       = res_q.cexc;
    assign force_zero = res_q.fz;
    assign force_qnan = res_q.fq;
endmodule

// File: rtl/fp_subnorm_trap_chk.sv
module fp_subnorm_trap_chk #(
    parameter int ER_W = 13
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic [2:0]             op,
    input logic                   dbl,
    input logic [3:0]             cls_a,
    input logic [3:0]             cls_b,
    input logic [3:0]             cls_r,
    input logic signed [ER_W-1:0] exp_est,
    input logic                   res_neg,
    input logic [1:0]             rnd_mode,
    input logic [4:0]             trap_en,
    input logic                   nonstd,
    input logic                   interval,
    input logic [4:0]             raw_flags,
    input logic                   out_valid,
    input logic [1:0]             trap_kind,
    input logic [4:0]             cexc,
    input logic                   force_zero,
    input logic                   force_qnan
);
    logic a_sub, b_sub;
    assign a_sub = (cls_a == 4'd4) || (cls_a == 4'd5);
    assign b_sub = (cls_b == 4'd4) || (cls_b == 4'd5);

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R1
    AST_TRAP_CODE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> trap_kind != 2'd3); // R12
    AST_FORCE_EXCL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(force_zero && force_qnan)); // R5
    AST_STD_ADD_UNFIN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (!nonstd || interval) && (op == 3'd0 || op == 3'd1)
         && a_sub && cls_b == 4'd1) |=> trap_kind == 2'd2); // R3
    AST_FLUSH_DIV_NV: assert property (@(posedge clk) disable iff (rst)
        (in_valid && nonstd && !interval && op == 3'd3 && a_sub && b_sub)
        |=> cexc[4]); // R8
endmodule

bind fp_subnorm_trap_unit fp_subnorm_trap_chk #(.ER_W(ER_W)) u_chk (.*);

// File: tb/tb_fp_subnorm_trap_unit.sv
module tb_fp_subnorm_trap_unit;
    localparam int ER_W = 13;
    // operation codes
    localparam logic [2:0] ADD = 0, SUB = 1, MUL = 2, DIV = 3, SQRT = 5, DTOS = 7;
    // class codes
    localparam logic [3:0] NON = 0, NRM = 1, PZ = 2, PS = 4, NS = 5, INF = 6;

    logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
    logic [2:0] op = '0;
    logic dbl = 1'b0, res_neg = 1'b0, nonstd = 1'b0, interval = 1'b0;
    logic [3:0] cls_a = '0, cls_b = '0, cls_r = '0;
    logic signed [ER_W-1:0] exp_est = '0;
    logic [1:0] rnd_mode = '0;
    logic [4:0] trap_en = '0, raw_flags = '0;
    logic out_valid, force_zero, force_qnan;
    logic [1:0] trap_kind;
    logic [4:0] cexc;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fp_subnorm_trap_unit dut (.*);

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fire(input logic [2:0] o, input logic d, input logic [3:0] a,
                        input logic [3:0] b, input logic [3:0] r, input int er,
                        input logic neg, input logic [1:0] rm, input logic [4:0] te,
                        input logic ns, input logic im, input logic [4:0] raw);
        @(negedge clk);
        op = o; dbl = d; cls_a = a; cls_b = b; cls_r = r;
        exp_est = ER_W'(er); res_neg = neg; rnd_mode = rm; trap_en = te;
        nonstd = ns; interval = im; raw_flags = raw; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string tag, input int tt, input int cx,
                              input bit fz, input bit fq);
        check({tag, " valid"}, out_valid, 1);
        check({tag, " trap"},  trap_kind, tt);
        check({tag, " cexc"},  cexc, cx);
        check({tag, " fz"},    force_zero, fz);
        check({tag, " fq"},    force_qnan, fq);
    endtask

    task automatic t_reset_and_latency();
        check("R1 reset valid", out_valid, 0);
        fire(ADD, 0, NRM, NRM, NRM, 100, 0, 0, 0, 0, 0, 0);
        expect_out("R1 plain", 0, 0, 0, 0);
        @(negedge clk);
        check("R1 valid drop", out_valid, 0);
    endtask

    task automatic t_std_addsub();
        fire(ADD, 0, PS, NRM, NRM, 0, 0, 0, 0, 0, 0, 0);
        expect_out("R3 add sub", 2, 0, 0, 0);
        fire(SUB, 0, PS, INF, INF, 0, 0, 0, 0, 0, 0, 0);
        expect_out("R3 sub inf", 0, 0, 0, 0);
        fire(ADD, 0, PS, NRM, NRM, 0, 0, 0, 0, 1, 1, 0);
        expect_out("R2 interval std", 2, 0, 0, 0);
        fire(ADD, 0, PS, NRM, NRM, 0, 0, 0, 0, 1, 0, 0);
        expect_out("R2 flush nx", 0, 5'h01, 0, 0);
    endtask

    task automatic t_std_muldiv();
        fire(MUL, 0, PS, NRM, NRM, -10, 0, 0, 0, 0, 0, 0);
        expect_out("R4 mul window", 2, 0, 0, 0);
        fire(MUL, 0, PS, NRM, PZ, -30, 0, 0, 0, 0, 0, 0);
        expect_out("R4 mul guzr", 0, 5'h05, 1, 0);
        fire(MUL, 0, PS, NRM, PZ, -30, 0, 2, 0, 0, 0, 0);
        expect_out("R4 mul rp pos", 2, 0, 0, 0);
        fire(MUL, 0, PS, NRM, PZ, -30, 0, 3, 0, 0, 0, 0);
        expect_out("R4 mul rm pos", 0, 5'h05, 1, 0);
        fire(DIV, 1, PS, NRM, INF, 2047, 0, 0, 0, 0, 0, 0);
        expect_out("R4 R11 div gor", 0, 5'h09, 0, 0);
        fire(DIV, 1, PS, NRM, INF, 2047, 0, 0, 5'h08, 0, 0, 0);
        expect_out("R11 of en", 1, 5'h08, 0, 0);
        fire(DIV, 1, PS, NRM, INF, 2047, 0, 0, 5'h01, 0, 0, 0);
        expect_out("R11 nx en", 1, 5'h01, 0, 0);
    endtask

    task automatic t_std_sqrt();
        fire(SQRT, 0, NON, NS, NRM, 0, 1, 0, 0, 0, 0, 0);
        expect_out("R5 sqrt neg", 0, 5'h10, 0, 1);
        fire(SQRT, 0, NON, NS, NRM, 0, 1, 0, 5'h10, 0, 0, 0);
        expect_out("R5 sqrt neg en", 1, 5'h10, 0, 1);
        fire(SQRT, 0, NON, PS, NRM, 0, 0, 0, 0, 0, 0, 0);
        expect_out("R5 sqrt pos", 2, 0, 0, 0);
    endtask

    task automatic t_flush_results();
        fire(ADD, 0, NRM, NRM, PZ, 0, 0, 0, 0, 1, 0, 5'h05);
        expect_out("R6 R7 zero uf nx", 0, 5'h05, 1, 0);
        fire(ADD, 0, NRM, NRM, PZ, 0, 0, 0, 0, 1, 0, 5'h00);
        expect_out("R6 exact zero", 0, 0, 0, 0);
        fire(MUL, 0, NRM, NRM, PS, 300, 0, 0, 0, 1, 0, 5'h05);
        expect_out("R7 mul gor", 0, 5'h09, 0, 0);
        fire(DTOS, 0, NON, NRM, PS, -5, 0, 0, 0, 1, 0, 5'h05);
        expect_out("R7 dtos zero", 0, 5'h05, 1, 0);
    endtask

    task automatic t_flush_div();
        fire(DIV, 0, PS, PS, NRM, 0, 0, 0, 0, 1, 0, 0);
        expect_out("R8 both sub", 0, 5'h10, 0, 0);
        fire(DIV, 0, NRM, PS, INF, 0, 0, 0, 0, 1, 0, 0);
        expect_out("R8 divisor sub", 0, 5'h02, 0, 0);
        fire(DIV, 0, NRM, PS, INF, 0, 0, 0, 5'h02, 1, 0, 0);
        expect_out("R8 R9 dz en", 1, 5'h02, 0, 0);
        fire(DIV, 0, PS, NRM, PZ, 0, 0, 0, 0, 1, 0, 0);
        expect_out("R8 dividend sub", 0, 5'h01, 0, 0);
        fire(DIV, 0, PS, PZ, INF, 0, 0, 0, 0, 1, 0, 0);
        expect_out("R8 zero opnd", 0, 5'h10, 0, 0);
    endtask

    task automatic t_priority();
        fire(ADD, 0, NRM, NRM, NRM, 0, 0, 0, 5'h10, 0, 0, 5'h12);
        expect_out("R9 nv en", 1, 5'h12, 0, 0);
        fire(ADD, 0, NRM, NRM, NRM, 0, 0, 0, 5'h10, 0, 0, 5'h1A);
        expect_out("R9 of first", 0, 5'h09, 0, 0);
        fire(ADD, 0, NRM, NRM, NRM, 0, 0, 0, 5'h04, 0, 0, 5'h05);
        expect_out("R10 ur uf en", 1, 5'h04, 0, 0);
        fire(ADD, 0, NRM, NRM, NRM, 0, 0, 0, 5'h01, 0, 0, 5'h05);
        expect_out("R10 ur nx en", 1, 5'h01, 0, 0);
        fire(ADD, 0, NRM, NRM, NRM, 0, 0, 0, 5'h01, 0, 0, 5'h01);
        expect_out("R9 R12 nx trap", 1, 5'h01, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset_and_latency();
        t_std_addsub();
        t_std_muldiv();
        t_std_sqrt();
        t_flush_results();
        t_flush_div();
        t_priority();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule